// File: doc/BRIEF.md
# Wrapping Burst Read Engine

This block is the read side of a memory with a synchronous burst interface and a 32-bit data bus. When burst mode is on, the host latches a word address with an address strobe. After a programmable number of clocks the engine returns one word per clock. The words stay inside the aligned group of 2, 4 or 8 words that holds the start address. They begin at the addressed word, count upward and roll over at the group boundary. If the clock keeps running, the same group repeats. An indicator output is pulled active during the word whose successor would be the start word again, which tells the host to issue a fresh strobe.

A seven-bit configuration register holds a burst-enable bit, the group length and the latency. After reset it selects plain asynchronous reads, in which the data follows the address combinationally. Reads of the configuration register and of the protection word never use the burst engine, even when burst mode is on. The secured space accepts word addresses only below its 256-byte limit. Deasserting chip enable ends a burst at once. A new address strobe during a burst throws the old address away and starts over.

The storage itself is a combinational model. The bus tri-state is shown as a drive-enable output plus a data-valid output. The open-drain indicator is shown as a level plus its own drive enable.

Top module: `wrap_burst_reader`

## Requirements
- R1: After synchronous reset the configuration register holds 7'h78: asynchronous mode, length code 00, latency field 4'hF. An asynchronous configuration read returns this value zero-extended to 32 bits.
- R2: When the configuration register is read, or burst mode is off, a read with ce_n and oe_n both low sets dout_oe and returns the word for rd_space/addr in the same cycle. Space 00 (array) returns (addr*32'h9E3779B1)^32'h13579BDF. Space 11 (secured) returns that value ^32'hFFFF0000. With oe_n or ce_n high, dout_oe and dout_valid are low and dout is zero.
- R3: In burst mode a latch edge is a rising edge with ce_n=0, adv_n=0 and rd_space 00 or 11. With latency field f, the count is L = f+1, except that f=0 gives L=2. The first word is valid in the cycle that ends at the L-th rising edge after the latch edge, and dout_valid is low before that.
- R4: Word j of a burst (j = 0, 1, ...) has word address base_aligned + ((start + j) mod N). N is 2 for length code 00, 4 for 01, and 8 for 10 or 11. The code is config bits [2:1]. The sequence repeats for as long as the clock runs.
- R5: During the valid word with (j mod N) = N-1, ind_oe is high and ind_n is low. At all other times ind_oe is low and ind_n is high.
- R6: While ce_n is high, dout_oe, dout_valid and ind_oe are low. The burst is dropped at the next edge, so lowering ce_n again without a latch edge yields no data.
- R7: A latch edge during a running burst discards the old address. Data stays invalid while adv_n is held low, and the latency restarts from the last edge with adv_n low.
- R8: In burst mode, reads of space 01 (configuration) and 10 (protection word, default 32'h000000A5) are combinational. They stay valid for as long as ce_n and oe_n are low, for any number of clocks, and need no address strobe.
- R9: Bursts start only after config bit 0 has been written to 1. Before that, adv_n has no effect and reads stay asynchronous.
- R10: In space 11, any word at a word address of 64 or more drives the bus (dout_oe high) with dout_valid low. This holds in both modes.
- R11: cfg_we at a rising edge loads cfg_wdata. The layout is [6:3] latency minus one, [2:1] length code, [0] burst enable. A burst latched at the same edge uses the previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_space | input | 2 | Read space: 00 array, 01 config, 10 protection, 11 secured |
| addr | input | ADDR_W | Word address |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 7 | Configuration write value |
| dout | output | 32 | Read data, zero when not valid |
| dout_oe | output | 1 | Data bus drive enable |
| dout_valid | output | 1 | Data on dout is valid |
| ind_n | output | 1 | Wrap indicator level, active low |
| ind_oe | output | 1 | Wrap indicator drive enable |

## Verification
The bench builds the block with its default values: ADDR_W of 16, a 256-byte secured space and the default protection word. With these values the 64-word secured limit can be reached from both sides with short bursts starting at 16'h003C and 16'h0044. The 16-bit address lets bursts start at group offsets that are not zero, for all three lengths. It runs the latency at 2 (through the zero field), 4 and 16. It aborts and restarts bursts in the middle of the data phase and in the middle of the wait, and mixes configuration and protection reads into a burst.

// File: rtl/wbr_pkg.sv
package wbr_pkg;

    localparam int DATA_W = 32;
    localparam int CFG_W  = 7;
    localparam int OFF_W  = 3;
    localparam int LAT_W  = 5;

    typedef enum logic [1:0] {
        SP_ARRAY  = 2'b00,
        SP_CONFIG = 2'b01,
        SP_PROT   = 2'b10,
        SP_SECURE = 2'b11
    } space_e;

    typedef enum logic [1:0] {
        LEN_2  = 2'b00,
        LEN_4  = 2'b01,
        LEN_8  = 2'b10,
        LEN_8X = 2'b11
    } blen_e;

    typedef struct packed {
        logic [3:0] lat_m1;
        blen_e      blen;
        logic       burst_en;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{lat_m1: 4'hF, blen: LEN_2, burst_en: 1'b0};

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_WAIT = 2'b01,
        ST_DATA = 2'b10
    } bst_e;

    function automatic logic [OFF_W-1:0] len_mask(blen_e b);
        case (b)
            LEN_2:   return 3'b001;
            LEN_4:   return 3'b011;
            default: return 3'b111;
        endcase
    endfunction

    function automatic logic [LAT_W-1:0] lat_clocks(logic [3:0] f);
        if (f == 4'd0) return 5'd2;
        return {1'b0, f} + 5'd1;
    endfunction

    function automatic logic [DATA_W-1:0] array_word(logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h13579BDF;
    endfunction

    function automatic logic [DATA_W-1:0] secure_word(logic [31:0] a);
        return array_word(a) ^ 32'hFFFF0000;
    endfunction

endpackage

// File: rtl/wbr_cfg_reg.sv
module wbr_cfg_reg
    import wbr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output cfg_t             cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (wr_en) begin
            cfg_q <= cfg_t'(wr_data);
        end
    end

endmodule

// File: rtl/wbr_wait_ctr.sv
module wbr_wait_ctr #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;

    // Loaded with clocks-1 at the latch edge; reaching 1 marks the edge
    // that opens the data phase.
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expire = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/wbr_wrap_seq.sv
module wbr_wrap_seq #(
    parameter int OFF_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [OFF_W-1:0] start_off,
    input  logic [OFF_W-1:0] mask,
    input  logic             advance,
    output logic [OFF_W-1:0] cur_off,
    output logic [OFF_W-1:0] grp_mask,
    output logic             last_beat
);

    logic [OFF_W-1:0] off_q;
    logic [OFF_W-1:0] first_q;
    logic [OFF_W-1:0] mask_q;
    logic [OFF_W-1:0] next_off;

    assign next_off = (off_q + OFF_W'(1)) & mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            off_q   <= '0;
            first_q <= '0;
            mask_q  <= '0;
        end else if (start) begin
            mask_q  <= mask;
            off_q   <= start_off & mask;
            first_q <= start_off & mask;
        end else if (advance) begin
            off_q <= next_off;
        end
    end

    assign cur_off   = off_q;
    assign grp_mask  = mask_q;
    assign last_beat = (next_off == first_q);

endmodule

// File: rtl/wbr_array.sv
module wbr_array
    import wbr_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter int              SEC_WORDS = 64,
    parameter logic [DATA_W-1:0] PROT_WORD = 32'h0000_00A5
) (
    input  space_e              space,
    input  logic [ADDR_W-1:0]   addr,
    input  cfg_t                cfg,
    output logic [DATA_W-1:0]   data,
    output logic                in_range
);

    localparam logic [ADDR_W-1:0] SEC_LIMIT = ADDR_W'(SEC_WORDS);

    logic [31:0] a32;
    assign a32 = 32'(addr);

    always_comb begin
        in_range = 1'b1;
        unique case (space)
            SP_ARRAY:  data = array_word(a32);
            SP_CONFIG: data = DATA_W'(cfg);
            SP_PROT:   data = PROT_WORD;
            default: begin
                data     = secure_word(a32);
                in_range = (addr < SEC_LIMIT);
            end
        endcase
    end

endmodule

// File: rtl/wrap_burst_reader.sv
module wrap_burst_reader
    import wbr_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                SEC_BYTES = 256,
    parameter logic [DATA_W-1:0] PROT_WORD = 32'h0000_00A5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              adv_n,
    input  logic              oe_n,
    input  logic [1:0]        rd_space,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cfg_we,
    input  logic [6:0]        cfg_wdata,
    output logic [31:0]       dout,
    output logic              dout_oe,
    output logic              dout_valid,
    output logic              ind_n,
    output logic              ind_oe
);

    localparam int SEC_WORDS = SEC_BYTES / (DATA_W / 8);

    cfg_t              cfg;
    bst_e              st;
    logic [ADDR_W-1:0] base_q;
    space_e            lspace_q;
    space_e            cur_space;
    logic              is_mem;
    logic              direct;
    logic              start;
    logic              expire;
    logic              advance;
    logic [OFF_W-1:0]  cur_off;
    logic [OFF_W-1:0]  grp_mask;
    logic              last_beat;
    logic [ADDR_W-1:0] burst_addr;
    logic [ADDR_W-1:0] rd_addr;
    space_e            rd_sp;
    logic [DATA_W-1:0] rd_data;
    logic              rd_ok;

    assign cur_space = space_e'(rd_space);
    assign is_mem    = (cur_space == SP_ARRAY) || (cur_space == SP_SECURE);
    assign direct    = !cfg.burst_en || !is_mem;
    assign start     = !ce_n && !adv_n && cfg.burst_en && is_mem;
    assign advance   = (st == ST_DATA) && !ce_n && !start;

    wbr_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .cfg_q   (cfg)
    );

    wbr_wait_ctr #(.CNT_W(LAT_W)) u_wait (
        .clk      (clk),
        .rst      (rst),
        .clear    (ce_n),
        .load     (start),
        .load_val (lat_clocks(cfg.lat_m1)),
        .expire   (expire)
    );

    wbr_wrap_seq #(.OFF_W(OFF_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .start_off (addr[OFF_W-1:0]),
        .mask      (len_mask(cfg.blen)),
        .advance   (advance),
        .cur_off   (cur_off),
        .grp_mask  (grp_mask),
        .last_beat (last_beat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            base_q   <= '0;
            lspace_q <= SP_ARRAY;
        end else if (ce_n) begin
            st <= ST_IDLE;
        end else if (start) begin
            st       <= ST_WAIT;
            base_q   <= addr;
            lspace_q <= cur_space;
        end else if (st == ST_WAIT && expire) begin
            st <= ST_DATA;
        end
    end

    assign burst_addr = {base_q[ADDR_W-1:OFF_W], (base_q[OFF_W-1:0] & ~grp_mask) | cur_off};
    assign rd_addr    = direct ? addr : burst_addr;
    assign rd_sp      = direct ? cur_space : lspace_q;

    wbr_array #(
        .ADDR_W    (ADDR_W),
        .SEC_WORDS (SEC_WORDS),
        .PROT_WORD (PROT_WORD)
    ) u_array (
        .space    (rd_sp),
        .addr     (rd_addr),
        .cfg      (cfg),
        .data     (rd_data),
        .in_range (rd_ok)
    );

    always_comb begin
        dout_oe    = 1'b0;
        dout_valid = 1'b0;
        ind_oe     = 1'b0;
        if (direct) begin
            dout_oe    = !ce_n && !oe_n;
            dout_valid = dout_oe && rd_ok;
        end else if (!ce_n && st != ST_IDLE) begin
            dout_oe    = !oe_n;
            dout_valid = dout_oe && (st == ST_DATA) && rd_ok;
            ind_oe     = (st == ST_DATA) && last_beat;
        end
        ind_n = !ind_oe;
        dout  = dout_valid ? rd_data : '0;
    end

endmodule

// File: rtl/wbr_checker.sv
module wbr_checker
    import wbr_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int SEC_WORDS = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              ce_n,
    input logic              adv_n,
    input logic              oe_n,
    input logic [1:0]        rd_space,
    input logic [ADDR_W-1:0] addr,
    input logic              dout_oe,
    input logic              dout_valid,
    input logic              ind_oe,
    input logic              ind_n,
    input bst_e              st,
    input logic              cfg_en
);

    localparam logic [ADDR_W-1:0] SEC_LIMIT = ADDR_W'(SEC_WORDS);

    logic mem_sp;
    assign mem_sp = (rd_space == SP_ARRAY) || (rd_space == SP_SECURE);

    p_abort_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        ce_n |-> (!dout_oe && !dout_valid && !ind_oe));

    p_ind_level_r5: assert property (@(posedge clk) disable iff (rst)
        ind_oe |-> (!ind_n && !ce_n));

    p_ind_release_r5: assert property (@(posedge clk) disable iff (rst)
        !ind_oe |-> ind_n);

    p_latch_waits_r3: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !adv_n && cfg_en && mem_sp) |=> (st == ST_WAIT));

    p_data_after_wait_r3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DATA && $past(st) != ST_DATA) |-> ($past(st) == ST_WAIT));

    p_cfg_read_r8: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !oe_n && rd_space == SP_CONFIG) |-> dout_valid);

    p_sec_limit_r10: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && !ce_n && !oe_n && rd_space == SP_SECURE && addr >= SEC_LIMIT)
            |-> (dout_oe && !dout_valid));

    p_valid_needs_oe_r2: assert property (@(posedge clk) disable iff (rst)
        dout_valid |-> (dout_oe && !oe_n));

    p_async_no_ind_r9: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && st == ST_IDLE) |-> !ind_oe);

endmodule

bind wrap_burst_reader wbr_checker #(
    .ADDR_W    (ADDR_W),
    .SEC_WORDS (SEC_WORDS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ce_n       (ce_n),
    .adv_n      (adv_n),
    .oe_n       (oe_n),
    .rd_space   (rd_space),
    .addr       (addr),
    .dout_oe    (dout_oe),
    .dout_valid (dout_valid),
    .ind_oe     (ind_oe),
    .ind_n      (ind_n),
    .st         (st),
    .cfg_en     (cfg.burst_en)
);

// File: tb/tb_wrap_burst_reader.sv
module tb_wrap_burst_reader;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce_n = 1'b1, adv_n = 1'b1, oe_n = 1'b1;
    logic [1:0]    sp = 2'b00;
    logic [AW-1:0] a = '0;
    logic          we = 1'b0;
    logic [6:0]    wd = '0;
    logic [31:0]   dout;
    logic          dout_oe, dout_valid, ind_n, ind_oe;

    always #10 clk = ~clk;

    wrap_burst_reader dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .adv_n(adv_n), .oe_n(oe_n),
        .rd_space(sp), .addr(a), .cfg_we(we), .cfg_wdata(wd),
        .dout(dout), .dout_oe(dout_oe), .dout_valid(dout_valid),
        .ind_n(ind_n), .ind_oe(ind_oe)
    );

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    logic [6:0]    m_cfg = 7'h78;
    bit            m_act = 0;
    int            m_k, m_L, m_len, m_start;
    logic [AW-1:0] m_base;
    logic [1:0]    m_sp;

    function automatic bit [31:0] arr_val(bit [31:0] x);
        return (x * 32'h9E3779B1) ^ 32'h13579BDF;
    endfunction

    function automatic bit [31:0] mem_val(logic [1:0] s, logic [AW-1:0] x);
        case (s)
            2'b00:   return arr_val(32'(x));
            2'b01:   return {25'd0, m_cfg};
            2'b10:   return 32'h0000_00A5;
            default: return arr_val(32'(x)) ^ 32'hFFFF0000;
        endcase
    endfunction

    task automatic check(string tag);
        bit e_oe, e_val, e_ind;
        bit [31:0] e_dat;
        bit direct;
        e_oe = 0; e_val = 0; e_ind = 0; e_dat = 0;
        direct = !m_cfg[0] || sp == 2'b01 || sp == 2'b10;
        if (direct) begin
            e_oe  = !ce_n && !oe_n;
            e_val = e_oe && !(sp == 2'b11 && a >= 16'd64);
            if (e_val) e_dat = mem_val(sp, a);
        end else if (m_act && !ce_n) begin
            int j;
            logic [AW-1:0] wa;
            j    = m_k - (m_L - 1);
            e_oe = !oe_n;
            if (j >= 0) begin
                wa    = (m_base & ~AW'(m_len - 1)) | AW'((m_start + j) % m_len);
                e_val = e_oe && !(m_sp == 2'b11 && wa >= 16'd64);
                e_ind = ((j % m_len) == m_len - 1);
                if (e_val) e_dat = mem_val(m_sp, wa);
            end
        end
        n_chk++;
        if (dout_oe !== e_oe || dout_valid !== e_val || dout !== e_dat ||
            ind_oe !== e_ind || ind_n !== !e_ind) begin
            n_fail++;
            $display("FAIL %s t=%0t: oe/valid/ind_oe/ind_n/dout actual %b %b %b %b %h expected %b %b %b %b %h",
                     tag, $time, dout_oe, dout_valid, ind_oe, ind_n, dout,
                     e_oe, e_val, e_ind, !e_ind, e_dat);
        end
    endtask

    task automatic model_edge();
        if (rst) begin
            m_cfg = 7'h78;
            m_act = 0;
            return;
        end
        if (ce_n) begin
            m_act = 0;
        end else if (!adv_n && m_cfg[0] && (sp == 2'b00 || sp == 2'b11)) begin
            m_act   = 1;
            m_k     = 0;
            m_base  = a;
            m_sp    = sp;
            m_L     = (m_cfg[6:3] == 4'd0) ? 2 : int'(m_cfg[6:3]) + 1;
            m_len   = (m_cfg[2:1] == 2'b00) ? 2 : (m_cfg[2:1] == 2'b01) ? 4 : 8;
            m_start = int'(a) % m_len;
        end else if (m_act) begin
            m_k++;
        end
        if (we) m_cfg = wd;
    endtask

    // check mid-cycle, then model the edge; inputs change 1 ns after edges
    task automatic step(string tag, bit do_chk = 1);
        #5;
        if (do_chk) check(tag);
        @(posedge clk);
        model_edge();
        #1;
    endtask

    task automatic set(bit c, bit v, bit o, logic [1:0] s, logic [AW-1:0] x);
        ce_n = c; adv_n = v; oe_n = o; sp = s; a = x;
    endtask

    task automatic run(int n, string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic write_cfg(logic [6:0] v);
        set(1, 1, 1, 2'b00, '0);
        we = 1; wd = v;
        step("R11");
        we = 0;
    endtask

    task automatic burst(logic [1:0] s, logic [AW-1:0] x, int n, string tag);
        set(0, 0, 0, s, x);
        step(tag);
        adv_n = 1;
        run(n, tag);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: run still going, actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(posedge clk); #1;
        for (int i = 0; i < 3; i++) step("reset", 0);
        rst = 0;

        // R1: reset value of the configuration register
        set(0, 1, 0, 2'b01, '0);
        run(2, "R1");

        // R2: asynchronous array and secured reads, bus released by oe_n/ce_n
        set(0, 1, 0, 2'b00, 16'h0123); step("R2");
        set(0, 1, 0, 2'b00, 16'hBEEF); step("R2");
        set(0, 1, 1, 2'b00, 16'hBEEF); step("R2");
        set(1, 1, 0, 2'b00, 16'hBEEF); step("R2");
        set(0, 1, 0, 2'b11, 16'h0010); step("R2");

        // R9: strobe has no effect before burst enable is written
        set(0, 0, 0, 2'b00, 16'h0042); step("R9");
        set(0, 1, 0, 2'b00, 16'h0043); run(3, "R9");

        // R10: secured limit in asynchronous mode
        set(0, 1, 0, 2'b11, 16'h003F); step("R10");
        set(0, 1, 0, 2'b11, 16'h0040); step("R10");

        // R11/R8: enable burst, length 4, latency 4; read config back
        write_cfg(7'h1B);
        set(0, 1, 0, 2'b01, '0); run(4, "R8");

        // R3/R4/R5: 4-word group starting at offset 2
        burst(2'b00, 16'h0022, 12, "R4");
        set(1, 1, 1, 2'b00, '0); step("R6");

        // length 8, latency 2, start offset 5
        write_cfg(7'h0D);
        burst(2'b00, 16'h1235, 20, "R4");

        // R6: abort in data phase, then ce_n low with no strobe
        set(1, 1, 0, 2'b00, 16'h1235); run(2, "R6");
        set(0, 1, 0, 2'b00, 16'h1235); run(4, "R6");

        // length 2, latency 16, odd start
        write_cfg(7'h79);
        burst(2'b00, 16'h0777, 22, "R3");

        // R7: restart mid-burst, strobe held two edges
        set(0, 0, 0, 2'b00, 16'h0500); run(2, "R7");
        set(0, 1, 0, 2'b00, 16'h0500); run(6, "R7");
        set(0, 0, 0, 2'b00, 16'h0601); step("R7");
        adv_n = 1; run(20, "R7");

        // latency field 0 behaves as 2, length 4
        write_cfg(7'h03);
        burst(2'b00, 16'h0033, 10, "R3");
        // oe_n high mid-burst releases data but keeps sequencing
        oe_n = 1; run(3, "R5");
        oe_n = 0; run(3, "R5");
        // R8: protection and config reads while a burst is latched
        set(0, 1, 0, 2'b10, 16'h0100); run(5, "R8");
        set(0, 1, 0, 2'b01, 16'h0100); run(2, "R8");
        // abort during wait
        set(0, 0, 0, 2'b00, 16'h0070); step("R6");
        set(1, 1, 0, 2'b00, 16'h0070); step("R6");
        set(0, 1, 0, 2'b00, 16'h0070); run(3, "R6");

        // R10: secured bursts on both sides of the limit
        burst(2'b11, 16'h003C, 8, "R10");
        burst(2'b11, 16'h0044, 6, "R10");

        set(1, 1, 1, 2'b00, '0); step("R6");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule